// File: doc/BRIEF.md
# Tree Winner-Take-All Index Encoder

This block takes M unsigned values and reports both the largest one and the position it came from. A binary tree of two-input select-max cells carries the larger value of each pair one row closer to the root per clock. Each cell also keeps a complementary pair of decision flags that record which side won. Once the root has decided, an enable runs back down the tree along the winning branches, one row per clock. Each row has one shared bus bit, and only the enabled cell in that row drives it. Taken together, the row bits form the winner's index.

A single start pulse captures the inputs and clears every cell. No per-row reset is used. The backward enable comes from the exclusive-OR of the root's two flags, so it rises only after the root has resolved. When the index is complete, a done flag rises. Result and flag then hold until the next start pulse.

Top module: `wta_tree_encoder`

## Requirements
- R1: While `rst_n` is low, and right after its release, `done` is 0, `max_out` is 0 and `idx_out` is 0.
- R2: Once `done` is high, `max_out` equals the largest of the M values captured by the start pulse. Input i sits at `din[i*VAL_W +: VAL_W]`.
- R3: Once `done` is high, `idx_out` holds the position i of the largest value. On ties the lowest position wins. The root row supplies the MSB (1 = winner in the upper half), and each lower row supplies the next less significant bit.
- R4: `done` rises exactly 2*log2(M) clock edges after the edge that samples `go`. That is log2(M) edges after the backward enable rises.
- R5: `idx_out` reads 0 until the root cell has resolved. This covers the first log2(M)-1 edges after the start edge.
- R6: Input values are sampled only on the start edge, so later changes on `din` have no effect. While `done` is high and `go` is low, `done`, `idx_out` and `max_out` stay unchanged.
- R7: A `go` pulse at any time restarts the block. This includes mid-pass and the very edge on which `done` would rise. After that edge `done` and `idx_out` are 0, and the new result follows the timing of R4.
- R8: `max_out` shows the maximum log2(M) edges after the start edge, because the forward pass climbs one row per clock.
- R9: No cell ever has both decision flags high. Once a flag is set, it stays set until the next start pulse or reset.
- R10: An enabled cell passes the enable only to the child on its winning side. A child is never enabled unless its parent is enabled and chose it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse: capture `din`, clear all cells and restart |
| din | input | N_IN*VAL_W | M packed unsigned values, value i at bits i*VAL_W upward |
| max_out | output | VAL_W | Largest captured value |
| idx_out | output | log2(N_IN) | Position of the largest value |
| done | output | 1 | Result complete and held |

## Verification
A start pulse can fall on the same edge on which the backward pass finishes. On that edge the clear and the setting of `done` compete. The bench times a second `go` to land exactly on the edge where the first run's `done` would rise. It then requires `done` and `idx_out` to read 0 after that edge, and the second vector's result to appear a full 2*log2(M) edges later. A second case restarts while the enable is still travelling down the tree. In both cases, a result left over from the first run would show up as a wrong index or early `done`.

// File: rtl/wta_pkg.sv
package wta_pkg;
  // Select-max decision: the upper input wins only when strictly larger,
  // so equal values resolve toward the lower-indexed side.
  function automatic logic pick_hi(input logic [63:0] lo_val, input logic [63:0] hi_val);
    return hi_val > lo_val;
  endfunction

  // Heap number of the first cell in tree row r (row 1 sits above the leaves).
  function automatic int row_first(input int levels, input int r);
    return 1 << (levels - r);
  endfunction
endpackage

// File: rtl/wta_cell.sv
module wta_cell
  import wta_pkg::*;
#(
  parameter int VAL_W   = 8,
  parameter bit IS_ROOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [VAL_W-1:0] a,
  input  logic [VAL_W-1:0] b,
  input  logic             en_in,
  output logic [VAL_W-1:0] y,
  output logic             dec_lo,
  output logic             dec_hi,
  output logic             en
);
  logic hi_wins;
  assign hi_wins = pick_hi(64'(a), 64'(b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y      <= '0;
      dec_lo <= 1'b0;
      dec_hi <= 1'b0;
    end else if (clr) begin
      y      <= '0;
      dec_lo <= 1'b0;
      dec_hi <= 1'b0;
    end else if (load) begin
      y      <= hi_wins ? b : a;
      dec_hi <= hi_wins;
      dec_lo <= ~hi_wins;
    end
  end

  generate
    if (IS_ROOT) begin : g_root
      // backward pass starts as soon as the root flags differ
      assign en = en_in & (dec_lo ^ dec_hi);
    end else begin : g_inner
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   en <= 1'b0;
        else if (clr) en <= 1'b0;
        else          en <= en_in;
      end
    end
  endgenerate
endmodule

// File: rtl/wta_ctrl.sv
module wta_ctrl #(
  parameter int LVL = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           bottom_hit,
  output logic [LVL-1:0] vld,
  output logic           done
);
  // vld[l] high: row l+1 may load; grows by one row per clock after start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      done <= 1'b0;
    end else if (go) begin
      vld  <= LVL'(1);
      done <= 1'b0;
    end else begin
      vld  <= vld | (vld << 1);
      done <= done | bottom_hit;
    end
  end
endmodule

// File: rtl/wta_tree_encoder.sv
module wta_tree_encoder
  import wta_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int VAL_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [N_IN*VAL_W-1:0]    din,
  output logic [VAL_W-1:0]         max_out,
  output logic [$clog2(N_IN)-1:0]  idx_out,
  output logic                     done
);
  localparam int LVL = $clog2(N_IN);
  localparam int BOT = N_IN / 2;

  logic [VAL_W-1:0] leaf_q [N_IN];
  logic [VAL_W-1:0] node_y [1:N_IN-1];
  logic [N_IN-1:1]  dec_lo, dec_hi, en, en_in;
  logic [LVL-1:0]   vld;
  logic [LVL:1]     bus;
  logic             bottom_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_IN; i++) leaf_q[i] <= '0;
    end else if (go) begin
      for (int i = 0; i < N_IN; i++) leaf_q[i] <= din[i*VAL_W +: VAL_W];
    end
  end

  generate
    for (genvar k = 1; k < N_IN; k++) begin : g_node
      localparam int LV = LVL + 1 - $clog2(k + 1);
      logic [VAL_W-1:0] a_s, b_s;
      if (2 * k >= N_IN) begin : g_leafkids
        assign a_s = leaf_q[2*k - N_IN];
        assign b_s = leaf_q[2*k + 1 - N_IN];
      end else begin : g_cellkids
        assign a_s = node_y[2*k];
        assign b_s = node_y[2*k + 1];
      end
      if (k == 1) begin : g_top
        assign en_in[k] = 1'b1;
      end else if (k % 2 == 1) begin : g_hiside
        assign en_in[k] = en[k/2] & dec_hi[k/2];
      end else begin : g_loside
        assign en_in[k] = en[k/2] & dec_lo[k/2];
      end
      wta_cell #(.VAL_W(VAL_W), .IS_ROOT(k == 1)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (go),
        .load   (vld[LV-1]),
        .a      (a_s),
        .b      (b_s),
        .en_in  (en_in[k]),
        .y      (node_y[k]),
        .dec_lo (dec_lo[k]),
        .dec_hi (dec_hi[k]),
        .en     (en[k])
      );
    end

    for (genvar r = 1; r <= LVL; r++) begin : g_row
      localparam int FIRST = row_first(LVL, r);
      localparam int LAST  = 2 * FIRST - 1;
      // one shared bit per row; only an enabled cell can pull it high
      assign bus[r] = |(en[LAST:FIRST] & dec_hi[LAST:FIRST]);
    end
  endgenerate

  assign bottom_hit = |(en[N_IN-1:BOT] & (dec_lo[N_IN-1:BOT] | dec_hi[N_IN-1:BOT]));

  wta_ctrl #(.LVL(LVL)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .bottom_hit (bottom_hit),
    .vld        (vld),
    .done       (done)
  );

  assign max_out = node_y[1];
  assign idx_out = bus;
endmodule

// File: rtl/wta_tree_chk.sv
module wta_tree_chk #(
  parameter int N_IN  = 8,
  parameter int VAL_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    go,
  input logic                    done,
  input logic [$clog2(N_IN)-1:0] idx_out,
  input logic [VAL_W-1:0]        max_out,
  input logic [N_IN-1:1]         dec_lo,
  input logic [N_IN-1:1]         dec_hi,
  input logic [N_IN-1:1]         en
);
  localparam int LVL  = $clog2(N_IN);
  localparam int CMAX = 2 * LVL + 2;
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] since_go;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_go <= '0;
    else if (go)                      since_go <= CW'(1);
    else if (since_go != CW'(CMAX))   since_go <= since_go + CW'(1);
  end

  p_done_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> since_go == CW'(2 * LVL + 1));

  p_idx_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_lo[1] || dec_hi[1]) |-> idx_out == '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !go) |=> (done && $stable(idx_out) && $stable(max_out)));

  p_go_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (!done && idx_out == '0));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_lo & dec_hi) == '0);

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (((dec_lo & $past(dec_lo)) == $past(dec_lo)) &&
             ((dec_hi & $past(dec_hi)) == $past(dec_hi))));

  generate
    for (genvar k = 2; k < N_IN; k++) begin : g_side
      if (k % 2 == 1) begin : g_hi
        p_child_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
          en[k] |-> (en[k/2] && dec_hi[k/2]));
      end else begin : g_lo
        p_child_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
          en[k] |-> (en[k/2] && dec_lo[k/2]));
      end
    end
  endgenerate
endmodule

bind wta_tree_encoder wta_tree_chk #(.N_IN(N_IN), .VAL_W(VAL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .go      (go),
  .done    (done),
  .idx_out (idx_out),
  .max_out (max_out),
  .dec_lo  (dec_lo),
  .dec_hi  (dec_hi),
  .en      (en)
);

// File: tb/sim_wta_tree_encoder.sv
module sim_wta_tree_encoder;
  localparam int N   = 8;
  localparam int W   = 8;
  localparam int LVL = 3;
  localparam int NV  = 8;

  // value i in byte i; listed here as v7..v0
  localparam logic [63:0] VEC_IN [NV] = '{
    64'h0000000000000000, 64'h8070605040302010, 64'h0000000000FF0000,
    64'hFFFFFFFFFFFFFFFF, 64'h01C00203C0040506, 64'h7E7F7E7E7E7E7E7E,
    64'h0000000000000100, 64'h0000ABAA00000000 };
  localparam logic [2:0] VEC_IDX [NV] = '{3'd0, 3'd7, 3'd2, 3'd0, 3'd3, 3'd6, 3'd1, 3'd5};
  localparam logic [7:0] VEC_MAX [NV] = '{8'h00, 8'h80, 8'hFF, 8'hFF, 8'hC0, 8'h7F, 8'h01, 8'hAB};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         go = 1'b0;
  logic [63:0]  din = '0;
  logic [7:0]   max_out;
  logic [2:0]   idx_out;
  logic         done;
  int           errors = 0;
  int           checks = 0;

  always #4 clk = ~clk;

  wta_tree_encoder #(.N_IN(N), .VAL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .din(din),
    .max_out(max_out), .idx_out(idx_out), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the start edge
  task automatic start_go(input logic [63:0] v);
    din = v;
    go  = 1'b1;
    step();
    go  = 1'b0;
  endtask

  // walks the 2*LVL edges after a start edge and checks timing and result
  task automatic wait_result(input logic [63:0] v, input logic [2:0] eidx, input logic [7:0] emax);
    for (int c = 1; c <= 2 * LVL; c++) begin
      step();
      din = ~v; // R6: later input changes must be ignored
      if (c == LVL - 1) chk(idx_out == 3'd0, "R5 idx quiet before root", 64'(idx_out), 64'd0);
      if (c == LVL)     chk(max_out == emax, "R8 max after forward pass", 64'(max_out), 64'(emax));
      if (c == 2 * LVL - 1) chk(done == 1'b0, "R4 done not early", 64'(done), 64'd0);
      if (c == 2 * LVL) begin
        chk(done == 1'b1, "R4 done on time", 64'(done), 64'd1);
        chk(idx_out == eidx, "R3 R10 winner index", 64'(idx_out), 64'(eidx));
        chk(max_out == emax, "R2 max value", 64'(max_out), 64'(emax));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && max_out == 8'd0 && idx_out == 3'd0, "R1 in reset",
        {55'd0, done, max_out}, 64'd0);
    rst_n = 1'b1;
    step();
    chk(done == 1'b0 && max_out == 8'd0 && idx_out == 3'd0, "R1 after release",
        {55'd0, done, max_out}, 64'd0);

    // vector table: each run includes tie cases for R9 and hold checks for R6
    for (int n = 0; n < NV; n++) begin
      start_go(VEC_IN[n]);
      wait_result(VEC_IN[n], VEC_IDX[n], VEC_MAX[n]);
      for (int h = 0; h < 2; h++) begin
        step();
        din = VEC_IN[(n + 1) % NV];
        chk(done == 1'b1 && idx_out == VEC_IDX[n] && max_out == VEC_MAX[n], "R6 R9 result held",
            {53'd0, done, idx_out, max_out}, {53'd0, 1'b1, VEC_IDX[n], VEC_MAX[n]});
      end
    end

    // R7 restart while the enable travels down the tree
    start_go(64'h0102030405060708);
    for (int c = 1; c <= LVL + 1; c++) step();
    start_go(64'h9000000000000000);
    chk(done == 1'b0 && idx_out == 3'd0, "R7 restart mid pass clears",
        {60'd0, done, idx_out}, 64'd0);
    wait_result(64'h9000000000000000, 3'd7, 8'h90);

    // R7 start lands on the edge where done would rise
    start_go(64'h0000000033000000);
    for (int c = 1; c < 2 * LVL; c++) step();
    chk(done == 1'b0, "R4 done not yet", 64'(done), 64'd0);
    start_go(64'h0000000000000044);
    chk(done == 1'b0 && idx_out == 3'd0, "R7 start wins over completion",
        {60'd0, done, idx_out}, 64'd0);
    wait_result(64'h0000000000000044, 3'd0, 8'h44);

    // R1 asynchronous reset in mid run
    start_go(64'h00000000000000F0);
    step();
    step();
    step();
    rst_n = 1'b0;
    #1;
    chk(done == 1'b0 && max_out == 8'd0 && idx_out == 3'd0, "R1 reset mid run",
        {53'd0, done, idx_out, max_out}, 64'd0);
    step();
    rst_n = 1'b1;
    step();
    chk(done == 1'b0, "R1 stays idle without go", 64'(done), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule